// File: doc/BRIEF.md
# Privilege and Illegal-Instruction Trap Unit

This block sits after instruction decode and, for every issued instruction, chooses one of three outcomes: raise a program interrupt, stop the machine, or let the instruction retire normally. It looks at a decoded operation class, the raw 32-bit instruction word, a legality flag produced by the decoder, the address of the current instruction and the live machine state register.

When a trap is raised, the block saves the current address and a copy of the old machine state in two save/restore registers. It marks the trap reason in the saved copy only, redirects the next address to the program interrupt vector, and replaces the machine state with a fixed supervisor state. An attention operation executed with supervisor rights sets a sticky halt flag. After that, no later instruction has any effect. Otherwise the next address is the sequential one, or the branch target supplied by the execute stage.

All results are registered and appear one cycle after the issuing edge. A one-cycle `trap_taken` pulse marks the cycle in which the save registers, machine state and next address hold trap values.

Top module: `priv_trap_unit`

## Requirements
- R1: After reset, `trap_taken` and `halted` are 0, `nia` equals the reset address (0), and `srr0`, `srr1` and `msr_out` are 0.
- R2: Op classes 1 (attention), 2 (read state), 3 (write state), 4 (write state, doubleword) and 5 (interrupt return) are always privileged. Issuing one while the problem-state bit (big-endian bit 49 of `msr_in`) is 1 raises a trap in the next cycle, with the privilege reason (big-endian bit 45) set in `srr1`.
- R3: Op classes 6 and 7 (special-register read and write) are privileged only when `insn[20]` (counted from the LSB) is 1. With `insn[20]`=0 they never trap for privilege.
- R4: When `legal` is 0, an issued instruction of any class except 9 (condition-register field move) traps, with the illegal reason (big-endian bit 44) set in `srr1`. Class 9 is never treated as illegal.
- R5: The privilege check comes first. An instruction that is both privileged-in-user-mode and illegal adds only the privilege reason to `srr1`, and attention in user mode traps instead of halting.
- R6: On a trap, `srr0` equals the issuing `cia`, `srr1` equals the issuing `msr_in` OR-ed with the reason bit, and `nia` equals 0x700.
- R7: On a trap, `msr_out` is `msr_in` with big-endian bits 5, 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61, 62 cleared and bits 0 and 63 set. No reason bit appears in `msr_out`.
- R8: Attention issued without a privilege trap sets `halted`, which stays 1 until reset. While halted, issues change none of the outputs and raise no trap.
- R9: A non-trapping, non-halting issue sets `nia` to `br_target` if `br_valid` is 1, or to `cia`+4 otherwise. It copies `msr_in` to `msr_out` and leaves `srr0` and `srr1` unchanged.
- R10: `trap_taken` is high for exactly the one cycle after a trapping issue. A cycle with `issue`=0 leaves every output unchanged and `trap_taken` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction presented this cycle |
| op_class | input | 4 | Decoded operation class (0 other, 1..9 as in the requirements) |
| insn | input | 32 | Raw instruction word |
| legal | input | 1 | Decoder found a legal opcode |
| cia | input | 64 | Current instruction address |
| msr_in | input | 64 | Live machine state |
| br_valid | input | 1 | Execute stage supplies a branch target |
| br_target | input | 64 | Branch target address |
| trap_taken | output | 1 | One-cycle trap pulse |
| halted | output | 1 | Sticky halt flag |
| nia | output | 64 | Next instruction address |
| srr0 | output | 64 | Saved trap address |
| srr1 | output | 64 | Saved machine state with reason bit |
| msr_out | output | 64 | New machine state |

## Verification
Two checks can apply to the same instruction: the privilege check and the illegal-opcode check. The same overlap exists between the privilege check and the halt decision. The bench provokes both on purpose. It issues an interrupt return that is also flagged illegal in user mode, and an attention in user mode. It then judges that only the privilege reason bit is added to the saved state and that no halt occurs. The random phase draws the problem-state bit, the legality flag and instruction bit 20 independently, so these collisions recur. Every result is compared with a bench model that applies the checks in their defined order.

// File: rtl/priv_trap_unit.sv
module priv_trap_unit #(
  parameter logic [63:0] VECTOR       = 64'h700,
  parameter logic [63:0] RESET_PC     = 64'h0,
  parameter int          SPR_PRIV_BIT = 20,
  parameter int          PR_BIT       = 49,
  parameter int          SF_BIT       = 0,
  parameter int          LE_BIT       = 63,
  parameter int          PRIV_REASON  = 45,
  parameter int          ILLEG_REASON = 44,
  parameter int          CLR_N        = 15,
  parameter logic [CLR_N*8-1:0] CLR_BITS =
    {8'd58, 8'd59, 8'd52, 8'd55, 8'd48, 8'd62, 8'd31, 8'd38,
     8'd40, 8'd49, 8'd50, 8'd61, 8'd53, 8'd54, 8'd5}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [3:0]  op_class,
  input  logic [31:0] insn,
  input  logic        legal,
  input  logic [63:0] cia,
  input  logic [63:0] msr_in,
  input  logic        br_valid,
  input  logic [63:0] br_target,
  output logic        trap_taken,
  output logic        halted,
  output logic [63:0] nia,
  output logic [63:0] srr0,
  output logic [63:0] srr1,
  output logic [63:0] msr_out
);

  localparam logic [3:0] OP_ATTN  = 4'd1;
  localparam logic [3:0] OP_MFMSR = 4'd2;
  localparam logic [3:0] OP_RFI   = 4'd5;
  localparam logic [3:0] OP_MFSPR = 4'd6;
  localparam logic [3:0] OP_MTSPR = 4'd7;
  localparam logic [3:0] OP_MTCRF = 4'd9;

  function automatic logic [63:0] be(input int k);
    return 64'h1 << (63 - k);
  endfunction

  function automatic logic [63:0] clr_mask_f();
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < CLR_N; i++) m |= be(int'(CLR_BITS[i*8 +: 8]));
    return m;
  endfunction

  localparam logic [63:0] CLR_MASK = clr_mask_f();
  localparam logic [63:0] SET_MASK = (64'h1 << (63 - SF_BIT)) | (64'h1 << (63 - LE_BIT));

  logic accept, always_priv, spr_move, priv, in_user;
  logic priv_fault, do_halt, illeg_fault, take;
  logic [63:0] reason, seq_nia;

  assign accept      = issue & ~halted;
  assign always_priv = (op_class >= OP_ATTN) && (op_class <= OP_RFI);
  assign spr_move    = (op_class == OP_MFSPR) || (op_class == OP_MTSPR);
  assign priv        = always_priv | (spr_move & insn[SPR_PRIV_BIT]);
  assign in_user     = msr_in[63 - PR_BIT];
  assign priv_fault  = accept & priv & in_user;
  assign do_halt     = accept & ~priv_fault & (op_class == OP_ATTN);
  assign illeg_fault = accept & ~priv_fault & ~do_halt & ~legal & (op_class != OP_MTCRF);
  assign take        = priv_fault | illeg_fault;
  assign reason      = priv_fault ? be(PRIV_REASON) : be(ILLEG_REASON);
  assign seq_nia     = br_valid ? br_target : cia + 64'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_taken <= 1'b0;
      halted     <= 1'b0;
      nia        <= RESET_PC;
      srr0       <= '0;
      srr1       <= '0;
      msr_out    <= '0;
    end else begin
      trap_taken <= take;
      if (take) begin
        srr0    <= cia;
        srr1    <= msr_in | reason;
        msr_out <= (msr_in & ~CLR_MASK) | SET_MASK;
        nia     <= VECTOR;
      end else if (accept & ~do_halt) begin
        nia     <= seq_nia;
        msr_out <= msr_in;
      end
      if (do_halt) halted <= 1'b1;
    end
  end

  p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> (nia == VECTOR) && (srr0 == $past(cia)));

  p_sup_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> !msr_out[63 - PR_BIT] && msr_out[63 - SF_BIT] && msr_out[63 - LE_BIT]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(nia) && $stable(srr0) && $stable(msr_out) && !trap_taken);

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> $past(issue) && !$past(halted));

  p_user_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && srr1[63 - PRIV_REASON] && !$past(msr_in[63 - PRIV_REASON]))
      |-> $past(msr_in[63 - PR_BIT]));

endmodule

// File: tb/sim_priv_trap_unit.sv
`timescale 1ns/1ps
module sim_priv_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  op_class = '0;
  logic [31:0] insn = '0;
  logic        legal = 1'b1;
  logic [63:0] cia = '0, msr_in = '0, br_target = '0;
  logic        br_valid = 1'b0;
  logic        trap_taken, halted;
  logic [63:0] nia, srr0, srr1, msr_out;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [63:0] m_nia, m_srr0, m_srr1, m_msr;
  logic        m_trap, m_halt;

  always #4 clk = ~clk;

  priv_trap_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_class(op_class), .insn(insn),
    .legal(legal), .cia(cia), .msr_in(msr_in), .br_valid(br_valid),
    .br_target(br_target), .trap_taken(trap_taken), .halted(halted), .nia(nia),
    .srr0(srr0), .srr1(srr1), .msr_out(msr_out));

  function automatic logic [63:0] bb(input int k);
    return 64'h1 << (63 - k);
  endfunction

  function automatic logic [63:0] sup_msr(input logic [63:0] m);
    int clr [15] = '{5, 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61, 62};
    logic [63:0] r;
    r = m;
    foreach (clr[i]) r &= ~bb(clr[i]);
    return r | bb(0) | bb(63);
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "trap_taken", 64'(trap_taken), 64'(m_trap));
    chk(tag, "halted", 64'(halted), 64'(m_halt));
    chk(tag, "nia", nia, m_nia);
    chk(tag, "srr0", srr0, m_srr0);
    chk(tag, "srr1", srr1, m_srr1);
    chk(tag, "msr_out", msr_out, m_msr);
  endtask

  task automatic step(input logic iss, input logic [3:0] cls, input logic [31:0] w,
                      input logic lg, input logic [63:0] a, input logic [63:0] m,
                      input logic bv, input logic [63:0] bt);
    string tag;
    logic pv, user;
    pv   = (cls >= 1 && cls <= 5) || ((cls == 6 || cls == 7) && w[20]);
    user = m[63-49];
    m_trap = 1'b0;
    if (!iss) tag = "R10";
    else if (m_halt) tag = "R8";
    else if (pv && user) begin
      tag = !lg ? "R5" : (cls == 1) ? "R5" : (cls >= 6) ? "R3" : "R2";
      m_trap = 1'b1; m_srr0 = a; m_srr1 = m | bb(45); m_msr = sup_msr(m); m_nia = 64'h700;
    end else if (cls == 1) begin
      tag = "R8"; m_halt = 1'b1;
    end else if (!lg && cls != 9) begin
      tag = "R4";
      m_trap = 1'b1; m_srr0 = a; m_srr1 = m | bb(44); m_msr = sup_msr(m); m_nia = 64'h700;
    end else begin
      tag = (cls == 9) ? "R4" : (cls == 6 || cls == 7) ? "R3" : "R9";
      m_nia = bv ? bt : a + 64'd4; m_msr = m;
    end
    issue = iss; op_class = cls; insn = w; legal = lg; cia = a; msr_in = m;
    br_valid = bv; br_target = bt;
    @(posedge clk); @(negedge clk);
    compare_all(tag);
    if (m_trap) begin
      chk("R6", "trap nia", nia, 64'h700);
      chk("R6", "trap srr0", srr0, a);
      chk("R7", "trap msr", msr_out, sup_msr(m));
      @(negedge clk);
      issue = 1'b0;
      @(posedge clk); @(negedge clk);
      m_trap = 1'b0;
      chk("R10", "pulse ends", 64'(trap_taken), 64'd0);
    end
  endtask

  function automatic logic [63:0] rmsr(input bit user);
    logic [63:0] m;
    m = {$urandom, $urandom};
    m[63-49] = user;
    m[63-45] = 1'b0;
    m[63-44] = 1'b0;
    return m;
  endfunction

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    m_nia = '0; m_srr0 = '0; m_srr1 = '0; m_msr = '0; m_trap = 1'b0; m_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    step(1, 4'd2, 32'h0, 1, 64'h1000, rmsr(1), 0, 0);
    step(1, 4'd2, 32'h0, 1, 64'h1004, rmsr(0), 0, 0);
    step(1, 4'd7, 32'h0, 1, 64'h1008, rmsr(1), 0, 0);
    step(1, 4'd6, 32'h0010_0000, 1, 64'h100c, rmsr(1), 0, 0);
    step(1, 4'd0, 32'h1, 0, 64'h2000, rmsr(0), 0, 0);
    step(1, 4'd9, 32'h2, 0, 64'h2004, rmsr(1), 0, 0);
    step(1, 4'd5, 32'h3, 0, 64'h2008, rmsr(1), 0, 0);
    step(1, 4'd0, 32'h4, 1, 64'h200c, rmsr(0), 1, 64'h8000);
    step(0, 4'd0, 32'h0, 0, 64'h3000, rmsr(1), 0, 0);
    step(1, 4'd1, 32'h0, 1, 64'h3004, rmsr(1), 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      c = 4'($urandom_range(0, 9));
      if (c == 4'd1) c = 4'd0;
      step($urandom_range(0, 7) != 0, c, $urandom, $urandom_range(0, 3) != 0,
           {$urandom, $urandom}, rmsr($urandom_range(0, 1) == 1),
           $urandom_range(0, 1) == 1, {$urandom, $urandom});
    end

    step(1, 4'd1, 32'h0, 1, 64'h4000, rmsr(0), 0, 0);
    step(1, 4'd0, 32'h0, 0, 64'h4004, rmsr(0), 0, 0);
    step(1, 4'd3, 32'h0, 1, 64'h4008, rmsr(1), 1, 64'h10);
    chk("R8", "halted sticky", 64'(halted), 64'd1);

    done = 1;
    report();
  end
endmodule